// File: doc/BRIEF.md
# Clock-Enable Power Mode Controller

This block follows the low-power modes of a synchronous DRAM that are selected by the clock-enable input. On every rising clock edge it looks at clock enable at that edge and at the edge before, at the decoded command and at a summary of the device state. From these it moves between normal running, two kinds of clock suspend, power-down and self-refresh. It drives a clock-valid qualifier that the rest of the device uses to decide whether an edge counts. It drives a hold flag that freezes the output data beat during a read suspend.

In self-refresh the block produces refresh requests by itself. A free-running down-counter is loaded with an interval given in clock cycles, and it gives one refresh pulse each time it expires. Auto-refresh commands issued while running also produce a pulse. Every pulse advances a 13-bit refresh row counter. The default interval of 1560 cycles is about 7.8 µs at 200 MHz, which spreads 8192 row refreshes over 64 ms.

Top module: `cke_pwr_ctrl`

## Requirements
- R1: After reset the mode is RUN (code 0), clock-valid is 1, the refresh row is 0, and refresh pulse, hold and error flags are 0.
- R2: Clock-valid equals the clock-enable value sampled at the most recent rising edge, so it qualifies the next edge.
- R3: In RUN, clock enable sampled low with the device state active (1) or writing (3) enters active suspend (mode 1). With state reading (2) it enters read suspend (mode 2), and the hold output is 1 while in mode 2.
- R4: In RUN with the device idle (state 0), clock enable sampled low together with deselect (cmd 0) or NOP (cmd 1) enters power-down (mode 3).
- R5: In RUN with the device idle, clock enable sampled low together with refresh (cmd 2) enters self-refresh (mode 4). Any other command (cmd 3 to 7) is still executed and the block enters active suspend (mode 1).
- R6: Either suspend mode returns to RUN on the first edge that samples clock enable high, whatever the command.
- R7: Power-down or self-refresh returns to RUN on an edge that samples clock enable high with deselect or NOP.
- R8: An edge that samples clock enable high in power-down or self-refresh with any command other than deselect or NOP keeps the mode and raises the error output for exactly one cycle.
- R9: In RUN, refresh (cmd 2) with clock enable high at that edge and the edge before gives a one-cycle refresh pulse in the next cycle, and the refresh row grows by one.
- R10: In self-refresh a refresh pulse appears every SREF_CYCLES edges, the first SREF_CYCLES edges after entry, each advancing the refresh row. No pulse appears in any other mode unless R9 applies.
- R11: The refresh row counts modulo 2^ROW_W (8192 by default) and returns to its start value after 8192 refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cmd | input | 3 | Decoded command: 0 deselect, 1 NOP, 2 refresh, 3..7 other |
| dev_st | input | 2 | Device state: 0 idle, 1 active, 2 reading, 3 writing |
| clk_valid | output | 1 | Next edge is valid |
| pwr_mode | output | 3 | 0 RUN, 1 active suspend, 2 read suspend, 3 power-down, 4 self-refresh |
| dq_hold | output | 1 | Hold the driven data beat (read suspend) |
| exit_err | output | 1 | One-cycle flag for an exit attempt with a bad command |
| ref_pulse | output | 1 | One-cycle refresh request |
| ref_row | output | ROW_W | Refresh row counter |

## Verification
Clock enable is dropped from each device state (idle, active, reading, writing) and, when idle, with deselect, NOP, refresh and an activate. This tells apart the four entry targets and shows that the command is what picks power-down over self-refresh. Exits are tried with good and bad commands from both deep modes, and suspend is left with a non-NOP command, which shows that only the deep modes check the exit command. Self-refresh is held for several intervals to fix the pulse spacing and the first-pulse position. A run of 8192 auto-refreshes shows the row counter wrapping.

// File: rtl/cke_pm_pkg.sv
package cke_pm_pkg;

    typedef enum logic [2:0] {
        CMD_DESL = 3'd0,
        CMD_NOP  = 3'd1,
        CMD_REF  = 3'd2
    } cmd_e;

    typedef enum logic [1:0] {
        DEV_IDLE  = 2'd0,
        DEV_ACT   = 2'd1,
        DEV_READ  = 2'd2,
        DEV_WRITE = 2'd3
    } dev_e;

    typedef enum logic [2:0] {
        M_RUN      = 3'd0,
        M_SUSP_ACT = 3'd1,
        M_SUSP_RD  = 3'd2,
        M_PDN      = 3'd3,
        M_SREF     = 3'd4
    } mode_e;

endpackage

// File: rtl/cke_pm_fsm.sv
module cke_pm_fsm
    import cke_pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic [2:0] cmd,
    input  logic [1:0] dev_st,
    output logic       clk_valid,
    output mode_e      mode,
    output logic       exit_err,
    output logic       auto_ref,
    output logic       sref_start
);

    typedef struct packed {
        mode_e mode;
        logic  cke;
        logic  err;
    } fsm_t;

    fsm_t s_q, s_d;
    logic is_nop;

    assign is_nop = (cmd == CMD_DESL) || (cmd == CMD_NOP);

    always_comb begin
        s_d        = s_q;
        s_d.cke    = cke;
        s_d.err    = 1'b0;
        auto_ref   = 1'b0;
        sref_start = 1'b0;
        case (s_q.mode)
            M_RUN: begin
                if (s_q.cke && !cke) begin
                    if (dev_st == DEV_IDLE) begin
                        if (is_nop) begin
                            s_d.mode = M_PDN;
                        end else if (cmd == CMD_REF) begin
                            s_d.mode   = M_SREF;
                            sref_start = 1'b1;
                        end else begin
                            s_d.mode = M_SUSP_ACT;
                        end
                    end else if (dev_st == DEV_READ) begin
                        s_d.mode = M_SUSP_RD;
                    end else begin
                        s_d.mode = M_SUSP_ACT;
                    end
                end else if (s_q.cke && cke && cmd == CMD_REF) begin
                    auto_ref = 1'b1;
                end
            end
            M_SUSP_ACT, M_SUSP_RD: begin
                if (cke) s_d.mode = M_RUN;
            end
            M_PDN, M_SREF: begin
                if (cke) begin
                    if (is_nop) s_d.mode = M_RUN;
                    else        s_d.err  = 1'b1;
                end
            end
            default: s_d.mode = M_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode <= M_RUN;
            s_q.cke  <= 1'b1;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_valid = s_q.cke;
    assign mode      = s_q.mode;
    assign exit_err  = s_q.err;

    // R4: idle NOP/deselect with falling clock enable lands in power-down
    p_pdn_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && clk_valid && !cke && dev_st == DEV_IDLE && cmd <= 3'd1)
        |=> mode == M_PDN);

    // R5: idle refresh with falling clock enable lands in self-refresh
    p_sref_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && clk_valid && !cke && dev_st == DEV_IDLE && cmd == 3'd2)
        |=> mode == M_SREF);

    // R6: suspend is left on the first high clock enable
    p_susp_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_SUSP_ACT || mode == M_SUSP_RD) && cke) |=> mode == M_RUN);

    // R8: bad exit command keeps the deep mode and flags it
    p_exit_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_PDN || mode == M_SREF) && cke && cmd > 3'd1)
        |=> ($stable(mode) && exit_err));

endmodule

// File: rtl/cke_pm_reftimer.sv
module cke_pm_reftimer #(
    parameter int SREF_CYCLES = 1560,
    parameter int ROW_W       = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_sref,
    input  logic             sref_start,
    input  logic             auto_ref,
    output logic             ref_pulse,
    output logic [ROW_W-1:0] ref_row
);

    localparam int TMR_W = (SREF_CYCLES > 1) ? $clog2(SREF_CYCLES) : 1;
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(SREF_CYCLES - 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [ROW_W-1:0] row;
        logic             pulse;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d       = t_q;
        t_d.pulse = 1'b0;
        if (sref_start) begin
            t_d.tmr = RELOAD;
        end else if (in_sref) begin
            if (t_q.tmr == '0) begin
                t_d.tmr   = RELOAD;
                t_d.pulse = 1'b1;
                t_d.row   = t_q.row + 1'b1;
            end else begin
                t_d.tmr = t_q.tmr - 1'b1;
            end
        end
        if (auto_ref) begin
            t_d.pulse = 1'b1;
            t_d.row   = t_q.row + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.tmr   <= RELOAD;
            t_q.row   <= '0;
            t_q.pulse <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign ref_pulse = t_q.pulse;
    assign ref_row   = t_q.row;

    // R9: every pulse comes with a one-row step (wrapping)
    p_row_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> ref_row == $past(ref_row) + 1'b1);

    // R10: outside self-refresh and without auto-refresh no pulse follows
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sref && !auto_ref) |=> !ref_pulse);

endmodule

// File: rtl/cke_pwr_ctrl.sv
module cke_pwr_ctrl
    import cke_pm_pkg::*;
#(
    parameter int SREF_CYCLES = 1560,
    parameter int ROW_W       = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [2:0]       cmd,
    input  logic [1:0]       dev_st,
    output logic             clk_valid,
    output logic [2:0]       pwr_mode,
    output logic             dq_hold,
    output logic             exit_err,
    output logic             ref_pulse,
    output logic [ROW_W-1:0] ref_row
);

    mode_e mode;
    logic  auto_ref;
    logic  sref_start;

    cke_pm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cmd        (cmd),
        .dev_st     (dev_st),
        .clk_valid  (clk_valid),
        .mode       (mode),
        .exit_err   (exit_err),
        .auto_ref   (auto_ref),
        .sref_start (sref_start)
    );

    cke_pm_reftimer #(
        .SREF_CYCLES (SREF_CYCLES),
        .ROW_W       (ROW_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_sref    (mode == M_SREF),
        .sref_start (sref_start),
        .auto_ref   (auto_ref),
        .ref_pulse  (ref_pulse),
        .ref_row    (ref_row)
    );

    assign pwr_mode = mode;
    assign dq_hold  = (mode == M_SUSP_RD);

endmodule

// File: tb/sim_cke_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_cke_pwr_ctrl;

    localparam int N  = 12;
    localparam int RW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic [2:0]    cmd = 3'd1;
    logic [1:0]    dev_st = 2'd0;
    logic          clk_valid, dq_hold, exit_err, ref_pulse;
    logic [2:0]    pwr_mode;
    logic [RW-1:0] ref_row;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    int m_mode = 0, m_cv = 1, m_row = 0, m_pulse = 0, m_err = 0, m_tmr = N - 1;

    always #2.5 clk = ~clk;

    cke_pwr_ctrl #(.SREF_CYCLES(N), .ROW_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .dev_st(dev_st),
        .clk_valid(clk_valid), .pwr_mode(pwr_mode), .dq_hold(dq_hold),
        .exit_err(exit_err), .ref_pulse(ref_pulse), .ref_row(ref_row)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cv = 1; m_row = 0; m_pulse = 0; m_err = 0; m_tmr = N - 1;
        end else begin
            int pm;
            pm = m_mode;
            m_pulse = 0;
            m_err = 0;
            if (pm == 4) begin
                if (m_tmr == 0) begin
                    m_pulse = 1; m_tmr = N - 1; m_row = (m_row + 1) % (1 << RW);
                end else m_tmr = m_tmr - 1;
            end
            if (pm == 0) begin
                if (m_cv == 1 && cke == 1'b0) begin
                    if (dev_st == 2'd0) begin
                        if (cmd <= 3'd1) m_mode = 3;
                        else if (cmd == 3'd2) begin m_mode = 4; m_tmr = N - 1; end
                        else m_mode = 1;
                    end else if (dev_st == 2'd2) m_mode = 2;
                    else m_mode = 1;
                end else if (m_cv == 1 && cke == 1'b1 && cmd == 3'd2) begin
                    m_pulse = 1; m_row = (m_row + 1) % (1 << RW);
                end
            end else if (pm == 1 || pm == 2) begin
                if (cke) m_mode = 0;
            end else begin
                if (cke) begin
                    if (cmd <= 3'd1) m_mode = 0;
                    else m_err = 1;
                end
            end
            m_cv = cke ? 1 : 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(cur_req, int'(pwr_mode), m_mode, "mode");
        chk("R2", int'(clk_valid), m_cv, "clk_valid");
        chk("R3", int'(dq_hold), (m_mode == 2) ? 1 : 0, "dq_hold");
        chk("R8", int'(exit_err), m_err, "exit_err");
        chk("R10", int'(ref_pulse), m_pulse, "ref_pulse");
        chk("R11", int'(ref_row), m_row, "ref_row");
    endtask

    task automatic cyc(input logic c, input logic [2:0] k, input logic [1:0] d);
        cke = c; cmd = k; dev_st = d;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int start_row;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", int'(pwr_mode), 0, "reset mode");
        chk("R1", int'(clk_valid), 1, "reset clk_valid");
        chk("R1", int'(ref_row), 0, "reset row");
        compare();

        // R9 auto-refresh
        cur_req = "R9";
        cyc(1, 3'd2, 0);
        chk("R9", int'(ref_pulse), 1, "auto pulse");
        chk("R9", int'(ref_row), 1, "auto row");
        cyc(1, 3'd1, 0);
        cyc(1, 3'd2, 0);
        cyc(1, 3'd0, 0);

        // R4 power-down, R8 bad exit, R7 exit
        cur_req = "R4";
        cyc(0, 3'd1, 0);
        chk("R4", int'(pwr_mode), 3, "pdn entry");
        cyc(0, 3'd5, 0);
        cyc(0, 3'd2, 0);
        chk("R10", int'(ref_pulse), 0, "no pulse in pdn");
        cur_req = "R8";
        cyc(1, 3'd3, 0);
        chk("R8", int'(exit_err), 1, "pdn bad exit");
        chk("R8", int'(pwr_mode), 3, "pdn kept");
        cur_req = "R7";
        cyc(1, 3'd0, 0);
        chk("R7", int'(pwr_mode), 0, "pdn exit");
        cyc(1, 3'd1, 0);

        // R5 self-refresh, R10 pulses
        cur_req = "R5";
        start_row = int'(ref_row);
        cyc(0, 3'd2, 0);
        chk("R5", int'(pwr_mode), 4, "sref entry");
        cur_req = "R10";
        for (int i = 1; i <= 3 * N + 2; i++) begin
            cyc(0, 3'd1, 0);
            if (i == N - 1) chk("R10", int'(ref_pulse), 0, "no early pulse");
            if (i == N) chk("R10", int'(ref_pulse), 1, "first sref pulse");
            if (i == 2 * N) chk("R10", int'(ref_pulse), 1, "second sref pulse");
        end
        chk("R10", int'(ref_row), (start_row + 3) % (1 << RW), "sref row");
        cur_req = "R8";
        cyc(1, 3'd4, 0);
        chk("R8", int'(pwr_mode), 4, "sref kept");
        cur_req = "R7";
        cyc(1, 3'd1, 0);
        chk("R7", int'(pwr_mode), 0, "sref exit");

        // R5 idle with other command -> active suspend
        cur_req = "R5";
        cyc(0, 3'd3, 0);
        chk("R5", int'(pwr_mode), 1, "idle act suspend");
        cur_req = "R6";
        cyc(1, 3'd4, 1);
        chk("R6", int'(pwr_mode), 0, "suspend exit");

        // R3 suspends from active, writing, reading
        cur_req = "R3";
        cyc(0, 3'd1, 1);
        chk("R3", int'(pwr_mode), 1, "active suspend");
        cyc(0, 3'd4, 1);
        cyc(1, 3'd1, 1);
        cyc(0, 3'd0, 3);
        chk("R3", int'(pwr_mode), 1, "write suspend");
        cyc(1, 3'd5, 3);
        cyc(0, 3'd1, 2);
        chk("R3", int'(pwr_mode), 2, "read suspend");
        chk("R3", int'(dq_hold), 1, "read hold");
        cyc(0, 3'd1, 2);
        cur_req = "R6";
        cyc(1, 3'd6, 2);
        chk("R6", int'(dq_hold), 0, "hold released");
        cyc(0, 3'd2, 1);
        chk("R3", int'(pwr_mode), 1, "active suspend on ref");
        cyc(1, 3'd1, 0);

        // R11 wrap
        cur_req = "R11";
        start_row = int'(ref_row);
        for (int i = 0; i < (1 << RW); i++) cyc(1, 3'd2, 0);
        cyc(1, 3'd1, 0);
        chk("R11", int'(ref_row), start_row, "row wrap");

        finish_run();
    end

endmodule